// File: doc/BRIEF.md
# CAN Controller Low-Power Entry and Wake Handshake

This block decides when a CAN controller may stop its clocks. Two sources can ask for low power. One is a module-disable request. The other is a chip-wide doze request, which counts only while a software-owned doze-enable bit is set. A request is not granted at once. The block waits until the transmit and receive engines both report idle. Only then does it gate the clock and raise a read-only acknowledge bit that software can poll.

The block leaves low power in two ways. The first is that the request is withdrawn. The second is bus activity seen while dozing, when self wake-up is enabled. In that second case the block emits a one-cycle wake-up event and clears the doze-enable bit by itself. The bus-activity input is asynchronous to the block clock, so it is resynchronized first. The controller steps through four states: run, pending (waiting for idle), low power and a one-cycle waking state.

Top module: `canlp_ctrl`

## Requirements
- R1: After reset, `lp_ack_o` is 0, `clk_en_o` is 1, `wake_o` is 0 and `doze_en_o` is 0.
- R2: Low power is entered only when both `tx_busy_i` and `rx_busy_i` are low. With an active request, `lp_ack_o` rises on the first clock edge after the one at which the block has been pending and both busy inputs are low. From run with idle engines, this takes two edges.
- R3: `lp_ack_o` is 1 exactly while the block is in low power, and `clk_en_o` is 0 exactly then.
- R4: A doze request (`doze_req_i`=1) with `disable_req_i`=0 leads to low power only while `doze_en_o` is 1.
- R5: If the request is withdrawn while the block is still pending, the block returns to run and `lp_ack_o` never rises.
- R6: If the request is withdrawn while in low power, `lp_ack_o` falls and `clk_en_o` returns to 1 on the next edge. `wake_o` stays 0.
- R7: In low power with `disable_req_i`=0 and `self_wake_en_i`=1, synchronized bus activity does three things at the same edge: it drops `lp_ack_o`, raises `wake_o` and clears `doze_en_o` to 0.
- R8: Bus activity has no effect in low power when `self_wake_en_i` is 0 or when `disable_req_i` is 1.
- R9: `wake_o` is high for exactly one clock cycle per wake-up.
- R10: `bus_act_i` passes through `SYNC_STAGES` flops. A level raised after an edge produces the wake-up at edge number `SYNC_STAGES`+1 after it.
- R11: A write (`doze_en_wr_i`=1) loads `doze_en_wdata_i` into `doze_en_o` at the next edge. An automatic clear at the same edge takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disable_req_i | input | 1 | Module-disable request |
| doze_req_i | input | 1 | Chip-level doze request |
| doze_en_wr_i | input | 1 | Write strobe for the doze-enable bit |
| doze_en_wdata_i | input | 1 | Value written to the doze-enable bit |
| self_wake_en_i | input | 1 | Enables wake-up on bus activity |
| bus_act_i | input | 1 | Bus activity indication, asynchronous |
| tx_busy_i | input | 1 | Transmit engine busy |
| rx_busy_i | input | 1 | Receive engine busy |
| lp_ack_o | output | 1 | Read-only low-power acknowledge |
| clk_en_o | output | 1 | Clock-gate enable for the protocol engines |
| wake_o | output | 1 | One-cycle wake-up event |
| doze_en_o | output | 1 | Current doze-enable bit |

## Verification
The entry path is swept over every busy source (transmit only, receive only, both) and over busy lengths of zero to three cycles. These runs separate a correctly deferred grant from one that arrives early or late by a cycle. The wake path is swept over all four combinations of self wake-up enable and disable request, with bus activity present each time. These runs separate a true doze wake-up from activity that must be ignored, and they pin the synchronizer latency. Separate runs cover three more cases: a request dropped while pending, a doze request with the enable bit both clear and set, and a software write that collides with the automatic clear.

// File: rtl/canlp_pkg.sv
package canlp_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PEND = 2'd1,
    ST_LP   = 2'd2,
    ST_WAKE = 2'd3
  } lp_state_e;
endpackage

// File: rtl/canlp_sync.sv
module canlp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_flops
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[0] <= 1'b0;
        else         sr_q[0] <= d_i;
      end
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sr_q[i] <= 1'b0;
          else         sr_q[i] <= sr_q[i-1];
        end
      end
      assign q_o = sr_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/canlp_doze_reg.sv
module canlp_doze_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic wake_clr_i,
  output logic doze_en_o
);
  logic doze_en_q;

  // self-clear on wake beats a concurrent software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         doze_en_q <= 1'b0;
    else if (wake_clr_i) doze_en_q <= 1'b0;
    else if (wr_i)       doze_en_q <= wdata_i;
  end

  assign doze_en_o = doze_en_q;

  AST_DOZE_SELF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_clr_i |=> !doze_en_o); // R7
  AST_DOZE_WR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wake_clr_i) |=> (doze_en_o == $past(wdata_i))); // R11
endmodule

// File: rtl/canlp_fsm.sv
module canlp_fsm
  import canlp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic disable_req_i,
  input  logic doze_req_i,
  input  logic doze_en_i,
  input  logic self_wake_en_i,
  input  logic bus_act_i,
  input  logic tx_busy_i,
  input  logic rx_busy_i,
  output logic lp_ack_o,
  output logic clk_en_o,
  output logic wake_o,
  output logic wake_clr_o
);
  lp_state_e st_q, st_d;
  logic      wake_q;
  logic      req, idle, hit;

  assign req  = disable_req_i | (doze_req_i & doze_en_i);
  assign idle = ~tx_busy_i & ~rx_busy_i;
  // self wake only applies to a doze-only low-power stay
  assign hit  = (st_q == ST_LP) & self_wake_en_i & bus_act_i & ~disable_req_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (req) st_d = ST_PEND;
      ST_PEND: begin
        if (!req)      st_d = ST_RUN;
        else if (idle) st_d = ST_LP;
      end
      ST_LP:   if (hit || !req) st_d = ST_WAKE;
      ST_WAKE: st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      wake_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wake_q <= hit;
    end
  end

  assign lp_ack_o   = (st_q == ST_LP);
  assign clk_en_o   = (st_q != ST_LP);
  assign wake_o     = wake_q;
  assign wake_clr_o = hit;

  AST_ENTRY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lp_ack_o) |-> $past(!tx_busy_i && !rx_busy_i)); // R2
  AST_ENTRY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lp_ack_o) |-> $past(disable_req_i || (doze_req_i && doze_en_i))); // R4
  AST_PEND_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PEND && !req) |=> !lp_ack_o); // R5
  AST_WAKE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R9
  AST_WAKE_FROM_LP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (!lp_ack_o && $past(lp_ack_o))); // R7
  AST_NO_WAKE_ON_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_ack_o && disable_req_i) |=> !wake_o); // R8
endmodule

// File: rtl/canlp_ctrl.sv
module canlp_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic disable_req_i,
  input  logic doze_req_i,
  input  logic doze_en_wr_i,
  input  logic doze_en_wdata_i,
  input  logic self_wake_en_i,
  input  logic bus_act_i,
  input  logic tx_busy_i,
  input  logic rx_busy_i,
  output logic lp_ack_o,
  output logic clk_en_o,
  output logic wake_o,
  output logic doze_en_o
);
  logic bus_act_s;
  logic wake_clr;

  canlp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (bus_act_i),
    .q_o    (bus_act_s)
  );

  canlp_doze_reg u_doze (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (doze_en_wr_i),
    .wdata_i    (doze_en_wdata_i),
    .wake_clr_i (wake_clr),
    .doze_en_o  (doze_en_o)
  );

  canlp_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .disable_req_i  (disable_req_i),
    .doze_req_i     (doze_req_i),
    .doze_en_i      (doze_en_o),
    .self_wake_en_i (self_wake_en_i),
    .bus_act_i      (bus_act_s),
    .tx_busy_i      (tx_busy_i),
    .rx_busy_i      (rx_busy_i),
    .lp_ack_o       (lp_ack_o),
    .clk_en_o       (clk_en_o),
    .wake_o         (wake_o),
    .wake_clr_o     (wake_clr)
  );

  AST_GATE_MATCHES_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o != lp_ack_o); // R3
endmodule

// File: tb/sim_canlp_ctrl.sv
module sim_canlp_ctrl;
  localparam int SYNC = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic disable_req_i = 0, doze_req_i = 0, doze_en_wr_i = 0, doze_en_wdata_i = 0;
  logic self_wake_en_i = 0, bus_act_i = 0, tx_busy_i = 0, rx_busy_i = 0;
  logic lp_ack_o, clk_en_o, wake_o, doze_en_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i; // 50 MHz

  canlp_ctrl #(.SYNC_STAGES(SYNC)) u0 (.*);

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic write_doze(logic v);
    doze_en_wr_i = 1; doze_en_wdata_i = v;
    tick();
    doze_en_wr_i = 0;
    chk("R11", doze_en_o, v, "doze_en after write");
  endtask

  task automatic settle_run();
    disable_req_i = 0; doze_req_i = 0; bus_act_i = 0; self_wake_en_i = 0;
    tx_busy_i = 0; rx_busy_i = 0;
    repeat (SYNC + 3) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (2) tick();
    // R1 reset state
    chk("R1", lp_ack_o, 0, "lp_ack in reset");
    chk("R1", clk_en_o, 1, "clk_en in reset");
    rst_ni = 1;
    tick();
    chk("R1", lp_ack_o, 0, "lp_ack after reset");
    chk("R1", clk_en_o, 1, "clk_en after reset");
    chk("R1", wake_o, 0, "wake after reset");
    chk("R1", doze_en_o, 0, "doze_en after reset");

    // R2/R3/R6 sweep over busy source and busy length
    for (int mode = 1; mode <= 3; mode++) begin
      for (int n = 0; n <= 3; n++) begin
        disable_req_i = 1;
        if (n > 0) begin
          tx_busy_i = mode[0];
          rx_busy_i = mode[1];
          for (int k = 0; k < n; k++) begin
            tick();
            chk("R2", lp_ack_o, 0, "ack while busy");
            chk("R3", clk_en_o, 1, "clk_en while busy");
          end
          tx_busy_i = 0; rx_busy_i = 0;
        end else begin
          tick();
          chk("R2", lp_ack_o, 0, "ack one edge after request");
        end
        tick();
        chk("R2", lp_ack_o, 1, "ack once idle");
        chk("R3", clk_en_o, 0, "clk gated in low power");
        disable_req_i = 0;
        tick();
        chk("R6", lp_ack_o, 0, "ack after withdraw");
        chk("R6", clk_en_o, 1, "clk restored after withdraw");
        chk("R6", wake_o, 0, "no wake on withdraw");
        tick();
      end
    end

    // R4 doze gated by enable bit
    for (int en = 0; en <= 1; en++) begin
      write_doze(en[0]);
      doze_req_i = 1;
      repeat (3) tick();
      chk("R4", lp_ack_o, en[0], "doze entry vs enable");
      chk("R3", clk_en_o, !en[0], "clk_en vs doze entry");
      doze_req_i = 0;
      repeat (2) tick();
      chk("R4", lp_ack_o, 0, "ack after doze drop");
    end

    // R7/R8/R9/R10 sweep over self-wake enable and disable request
    for (int sw = 0; sw <= 1; sw++) begin
      for (int dis = 0; dis <= 1; dis++) begin
        automatic logic exp_wake = sw[0] & !dis[0];
        write_doze(1);
        doze_req_i = 1; disable_req_i = dis[0];
        repeat (2) tick();
        chk("R7", lp_ack_o, 1, "in low power before activity");
        self_wake_en_i = sw[0];
        bus_act_i = 1;
        for (int k = 0; k < SYNC; k++) begin
          tick();
          chk("R10", wake_o, 0, "no wake inside sync latency");
          chk("R10", lp_ack_o, 1, "ack held inside sync latency");
        end
        tick();
        chk(exp_wake ? "R7" : "R8", wake_o, exp_wake, "wake event");
        chk(exp_wake ? "R7" : "R8", lp_ack_o, !exp_wake, "ack at wake edge");
        chk(exp_wake ? "R7" : "R8", doze_en_o, !exp_wake, "doze_en self clear");
        tick();
        chk("R9", wake_o, 0, "wake lasts one cycle");
        chk(exp_wake ? "R7" : "R8", lp_ack_o, !exp_wake, "ack after wake");
        settle_run();
        chk("R8", lp_ack_o, 0, "back in run");
      end
    end

    // R5 drop while pending
    disable_req_i = 1; tx_busy_i = 1;
    repeat (2) tick();
    chk("R5", lp_ack_o, 0, "pending ack low");
    disable_req_i = 0;
    tick();
    chk("R5", lp_ack_o, 0, "ack after pending drop");
    tx_busy_i = 0;
    repeat (2) tick();
    chk("R5", lp_ack_o, 0, "no late entry");
    chk("R5", clk_en_o, 1, "clock never gated");

    // R11 clear beats simultaneous write
    write_doze(1);
    doze_req_i = 1;
    repeat (2) tick();
    self_wake_en_i = 1; bus_act_i = 1;
    repeat (SYNC) tick();
    doze_en_wr_i = 1; doze_en_wdata_i = 1;
    tick();
    doze_en_wr_i = 0;
    chk("R11", doze_en_o, 0, "clear wins over write");
    chk("R11", wake_o, 1, "wake at collision edge");
    settle_run();

    finish_run();
  end
endmodule